// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Interrupts

This block sits between a register interface and a serial bus engine. It has two byte queues. The transmit queue is filled by the register side and drained by the engine. The receive queue is filled by the engine and drained by the register side. Each queue has a programmable fill threshold. Crossing a threshold raises a sticky status bit: low fill for transmit, high fill for receive. A timer catches received bytes that stay in the queue below the threshold after traffic stops. Pushing into a full queue or popping from an empty one is recorded separately for each direction.

All four data edges use valid/ready. A queue shows `ready` only while it is enabled, not full and not in software reset. It shows `valid` only while it is enabled, not empty and not in software reset. A source should offer a byte only when ready is high. A beat offered to an enabled queue while ready is low because the queue is full is dropped and flagged as an overrun. A sink that raises ready on an enabled, empty queue gets no byte, and an underrun is flagged. The status bits are cleared by writing ones. A single interrupt line combines the status bits with an enable mask.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset both queues are empty and the status bits are zero. The status word reads 32'h0100_0100, the interrupt status reads 0 and the interrupt line is low.
- R2: Bytes accepted on the transmit input leave the transmit output in the same order, with none lost.
- R3: Bytes accepted on the receive input leave the receive output in the same order, with none lost.
- R4: In the status word, bits 6:0 hold the transmit fill level, bit 7 flags transmit full and bit 8 flags transmit empty. Bits 22:16 hold the receive fill level, bit 23 flags receive full and bit 24 flags receive empty. Every other bit reads 0. Ready is low while full, and valid is low while empty.
- R5: In the control word, bit 1 enables transmit and bits 22:16 hold the transmit threshold. While transmit is enabled and its level is at or below the threshold, interrupt status bit 0 is set one cycle later.
- R6: In the control word, bit 0 enables receive and bits 10:4 hold the receive threshold. While receive is enabled and its level is at or above the threshold, interrupt status bit 1 is set one cycle later.
- R7: A push offered to a full enabled queue sets bit 3 (transmit) or bit 5 (receive). The byte is discarded and the level does not change.
- R8: A pop requested from an empty enabled queue sets bit 2 (transmit) or bit 4 (receive).
- R9: Each accepted receive byte restarts a timer. If the receive queue is still non-empty T+1 cycles after the last accepted byte, where T is the 4-bit trailing limit, interrupt status bit 6 is set.
- R10: A clear strobe with a mask clears exactly the status bits whose mask bits are 1. A bit whose set condition holds in the same cycle stays set.
- R11: The interrupt line is high exactly when some status bit and its enable bit are both 1.
- R12: A cycle with soft reset high empties both queues and zeroes the status. Ready and valid stay low while soft reset is high.
- R13: A disabled queue holds ready and valid low, stores nothing, and flags neither overrun nor underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_ctl | input | 32 | Enables (bit 0 receive, bit 1 transmit) and thresholds (10:4 receive, 22:16 transmit) |
| soft_rst | input | 1 | Software reset: flushes both queues and the status |
| trail_limit | input | 4 | Trailing timer limit T |
| irq_en | input | 7 | Interrupt enable mask |
| irq_clr_we | input | 1 | Clear strobe for the status bits |
| irq_clr_mask | input | 7 | Bits cleared when the strobe is high |
| tx_in_valid | input | 1 | Transmit byte offered by the register side |
| tx_in_ready | output | 1 | Transmit queue can accept a byte |
| tx_in_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Transmit byte available to the engine |
| tx_out_ready | input | 1 | Engine takes the transmit byte |
| tx_out_data | output | 8 | Head of the transmit queue |
| rx_in_valid | input | 1 | Receive byte offered by the engine |
| rx_in_ready | output | 1 | Receive queue can accept a byte |
| rx_in_data | input | 8 | Receive byte |
| rx_out_valid | output | 1 | Receive byte available to the register side |
| rx_out_ready | input | 1 | Register side takes the receive byte |
| rx_out_data | output | 8 | Head of the receive queue |
| fifo_status | output | 32 | Levels and full/empty flags |
| irq_status | output | 7 | Sticky interrupt status |
| irq | output | 1 | Interrupt line |

## Verification
A transfer at a clock edge changes the levels, the flags, ready and valid right after that edge. The head byte is also visible then. Overrun and underrun bits are set by the edge of the offending request. The threshold bits are set one edge after the level reaches the threshold. The trailing bit is set T+1 edges after the last accepted receive byte. The interrupt line follows the status bits and the mask with no extra cycle. The bench drives inputs at the falling edge and checks at the next falling edge, or the one the latency above calls for. It checks the threshold and trailing bits one cycle before they are due, where they must still be clear, and again on the cycle they are due. A monitor samples the output handshakes 2 ns after the falling edge.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam int ST_W   = 7;
  localparam int LVL_W  = 7;
  localparam int B_TXAE = 0;
  localparam int B_RXAF = 1;
  localparam int B_TXUR = 2;
  localparam int B_TXOR = 3;
  localparam int B_RXUR = 4;
  localparam int B_RXOR = 5;
  localparam int B_TRL  = 6;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
endpackage

// File: rtl/dfifo_mem.sv
module dfifo_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       en,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [dfifo_pkg::LVL_W-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       ovr,
  output logic                       unr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          live, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign live    = en & ~flush;
  assign do_push = live & push & ~full;
  assign do_pop  = live & pop & ~empty;
  assign ovr     = live & push & full;
  assign unr     = live & pop & empty;
  assign rdata   = mem[rp];
  assign level   = dfifo_pkg::LVL_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/dfifo_trail.sv
module dfifo_trail #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rx_push,
  input  logic          rx_empty,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign expire = armed & ~rx_push & ~rx_empty & ~flush & (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (flush) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (rx_push) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (rx_empty || cnt == limit) armed <= 1'b0;
      else                          cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dfifo_irq.sv
module dfifo_irq #(
  parameter int SW = dfifo_pkg::ST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [SW-1:0] set,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_mask,
  input  logic [SW-1:0] enable,
  output logic [SW-1:0] status,
  output logic          irq
);
  logic [SW-1:0] clr;

  assign clr = clr_we ? clr_mask : '0;
  assign irq = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= '0;
    else if (flush) status <= '0;
    else            status <= (status & ~clr) | set;
  end
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fifo_ctl,
  input  logic        soft_rst,
  input  logic [3:0]  trail_limit,
  input  logic [6:0]  irq_en,
  input  logic        irq_clr_we,
  input  logic [6:0]  irq_clr_mask,
  input  logic        tx_in_valid,
  output logic        tx_in_ready,
  input  logic [7:0]  tx_in_data,
  output logic        tx_out_valid,
  input  logic        tx_out_ready,
  output logic [7:0]  tx_out_data,
  input  logic        rx_in_valid,
  output logic        rx_in_ready,
  input  logic [7:0]  rx_in_data,
  output logic        rx_out_valid,
  input  logic        rx_out_ready,
  output logic [7:0]  rx_out_data,
  output logic [31:0] fifo_status,
  output logic [6:0]  irq_status,
  output logic        irq
);
  localparam int NDIR = 2;

  logic [NDIR-1:0]  f_en, f_push, f_pop, f_full, f_empty, f_ovr, f_unr;
  logic [7:0]       f_wd  [NDIR];
  logic [7:0]       f_rd  [NDIR];
  logic [LVL_W-1:0] f_lvl [NDIR];
  logic [LVL_W-1:0] tx_trig, rx_trig;
  logic [ST_W-1:0]  st_set;
  logic             trail_hit;

  assign f_en[DIR_TX]   = fifo_ctl[1];
  assign f_en[DIR_RX]   = fifo_ctl[0];
  assign rx_trig        = fifo_ctl[10:4];
  assign tx_trig        = fifo_ctl[22:16];
  assign f_push[DIR_TX] = tx_in_valid;
  assign f_push[DIR_RX] = rx_in_valid;
  assign f_pop[DIR_TX]  = tx_out_ready;
  assign f_pop[DIR_RX]  = rx_out_ready;
  assign f_wd[DIR_TX]   = tx_in_data;
  assign f_wd[DIR_RX]   = rx_in_data;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    dfifo_mem #(.DEPTH(DEPTH), .DW(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (soft_rst),
      .en    (f_en[g]),
      .push  (f_push[g]),
      .wdata (f_wd[g]),
      .pop   (f_pop[g]),
      .rdata (f_rd[g]),
      .level (f_lvl[g]),
      .full  (f_full[g]),
      .empty (f_empty[g]),
      .ovr   (f_ovr[g]),
      .unr   (f_unr[g])
    );
  end

  assign tx_in_ready  = f_en[DIR_TX] & ~f_full[DIR_TX]  & ~soft_rst;
  assign tx_out_valid = f_en[DIR_TX] & ~f_empty[DIR_TX] & ~soft_rst;
  assign rx_in_ready  = f_en[DIR_RX] & ~f_full[DIR_RX]  & ~soft_rst;
  assign rx_out_valid = f_en[DIR_RX] & ~f_empty[DIR_RX] & ~soft_rst;
  assign tx_out_data  = f_rd[DIR_TX];
  assign rx_out_data  = f_rd[DIR_RX];

  dfifo_trail #(.TW(4)) u_trail (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (soft_rst),
    .rx_push  (rx_in_valid & rx_in_ready),
    .rx_empty (f_empty[DIR_RX]),
    .limit    (trail_limit),
    .expire   (trail_hit)
  );

  always_comb begin
    st_set         = '0;
    st_set[B_TXAE] = f_en[DIR_TX] & (f_lvl[DIR_TX] <= tx_trig);
    st_set[B_RXAF] = f_en[DIR_RX] & (f_lvl[DIR_RX] >= rx_trig);
    st_set[B_TXUR] = f_unr[DIR_TX];
    st_set[B_TXOR] = f_ovr[DIR_TX];
    st_set[B_RXUR] = f_unr[DIR_RX];
    st_set[B_RXOR] = f_ovr[DIR_RX];
    st_set[B_TRL]  = trail_hit;
  end

  dfifo_irq #(.SW(ST_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (soft_rst),
    .set      (st_set),
    .clr_we   (irq_clr_we),
    .clr_mask (irq_clr_mask),
    .enable   (irq_en),
    .status   (irq_status),
    .irq      (irq)
  );

  assign fifo_status = {7'd0, f_empty[DIR_RX], f_full[DIR_RX], f_lvl[DIR_RX],
                        7'd0, f_empty[DIR_TX], f_full[DIR_TX], f_lvl[DIR_TX]};
endmodule

// File: rtl/dual_fifo_irq_chk.sv
module dual_fifo_irq_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fifo_ctl,
  input logic        soft_rst,
  input logic        tx_in_valid,
  input logic        tx_in_ready,
  input logic        tx_out_valid,
  input logic        tx_out_ready,
  input logic        rx_in_valid,
  input logic        rx_in_ready,
  input logic        rx_out_valid,
  input logic        rx_out_ready,
  input logic [31:0] fifo_status,
  input logic [6:0]  irq_status
);
  assert_tx_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && fifo_status[7] && fifo_ctl[1] && !soft_rst) |=> irq_status[3]);

  assert_rx_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && fifo_status[23] && fifo_ctl[0] && !soft_rst) |=> irq_status[5]);

  assert_tx_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_ready && fifo_status[8] && fifo_ctl[1] && !soft_rst) |=> irq_status[2]);

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_status[7] |-> !tx_in_ready) and (fifo_status[23] |-> !rx_in_ready));

  assert_empty_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_status[8] |-> !tx_out_valid) and (fifo_status[24] |-> !rx_out_valid));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_status[6:0]) <= DEPTH) && (int'(fifo_status[22:16]) <= DEPTH));

  assert_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (fifo_status == 32'h0100_0100) && (irq_status == 7'd0));

  assert_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ctl[1] |-> (!tx_in_ready && !tx_out_valid));
endmodule

bind dual_fifo_irq dual_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_ctl     (fifo_ctl),
  .soft_rst     (soft_rst),
  .tx_in_valid  (tx_in_valid),
  .tx_in_ready  (tx_in_ready),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .rx_in_valid  (rx_in_valid),
  .rx_in_ready  (rx_in_ready),
  .rx_out_valid (rx_out_valid),
  .rx_out_ready (rx_out_ready),
  .fifo_status  (fifo_status),
  .irq_status   (irq_status)
);

// File: tb/dual_fifo_irq_tb_top.sv
module dual_fifo_irq_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fifo_ctl = '0;
  logic        soft_rst = 1'b0;
  logic [3:0]  trail_limit = 4'd5;
  logic [6:0]  irq_en = '0;
  logic        irq_clr_we = 1'b0;
  logic [6:0]  irq_clr_mask = '0;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0]  tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid, irq;
  logic [7:0]  tx_out_data, rx_out_data;
  logic [31:0] fifo_status;
  logic [6:0]  irq_status;

  int checks = 0;
  int fails  = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #4 clk = ~clk;

  dual_fifo_irq #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_in_valid = 1'b1;
    tx_in_data  = d;
    if (tx_in_ready) tx_q.push_back(d);
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1'b1;
    rx_in_data  = d;
    if (rx_in_ready) rx_q.push_back(d);
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_pop();
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  task automatic rx_pop();
    rx_out_ready = 1'b1;
    @(negedge clk);
    rx_out_ready = 1'b0;
  endtask

  task automatic clr_status(input logic [6:0] m);
    irq_clr_we   = 1'b1;
    irq_clr_mask = m;
    @(negedge clk);
    irq_clr_we   = 1'b0;
  endtask

  // scoreboard monitor: compares every handshake against the expected queues
  always @(negedge clk) begin
    #2;
    if (tx_out_valid && tx_out_ready) begin
      if (tx_q.size() == 0) chk(32'(tx_out_data), 32'hFFFF_FFFF, "R2 unexpected tx byte");
      else chk(32'(tx_out_data), 32'(tx_q.pop_front()), "R2 tx order");
    end
    if (rx_out_valid && rx_out_ready) begin
      if (rx_q.size() == 0) chk(32'(rx_out_data), 32'hFFFF_FFFF, "R3 unexpected rx byte");
      else chk(32'(rx_out_data), 32'(rx_q.pop_front()), "R3 rx order");
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_status, 32'h0100_0100, "R1 status word");
    chk(32'(irq_status), 0, "R1 irq status");
    chk(32'(irq), 0, "R1 irq line");

    // R13: disabled queues
    chk(32'({tx_in_ready, rx_out_valid}), 0, "R13 ready/valid low");
    tx_push(8'h55);
    rx_push(8'h66);
    chk(fifo_status, 32'h0100_0100, "R13 nothing stored");
    chk(32'(irq_status), 0, "R13 no flags");

    // enable: tx threshold 2, rx threshold 4
    fifo_ctl = (32'd2 << 16) | (32'd4 << 4) | 32'd3;
    @(negedge clk);
    chk(32'(irq_status[0]), 1, "R5 tx almost empty");
    chk(32'(irq), 0, "R11 masked");
    irq_en = 7'h01;
    #1;
    chk(32'(irq), 1, "R11 enabled");
    irq_en = 7'h00;
    clr_status(7'h7F);
    chk(32'(irq_status[0]), 1, "R10 set wins over clear");

    for (int i = 0; i < DEPTH; i++) tx_push(8'(8'h10 + i));
    chk(32'(fifo_status[8:0]), 32'(9'h080 | DEPTH), "R4 tx full level");
    chk(32'(tx_in_ready), 0, "R4 full blocks ready");
    tx_push(8'hEE);
    chk(32'(irq_status[3]), 1, "R7 tx overrun");
    chk(32'(fifo_status[6:0]), DEPTH, "R7 level unchanged");
    clr_status(7'h01);
    chk(32'(irq_status), 32'h08, "R10 masked clear");
    irq_en = 7'h08;
    #1;
    chk(32'(irq), 1, "R11 overrun irq");
    irq_en = 7'h00;

    for (int i = 0; i < DEPTH; i++) tx_pop();
    chk(32'(irq_status[0]), 1, "R5 drained below threshold");
    tx_pop();
    chk(32'(irq_status[2]), 1, "R8 tx underrun");
    chk(32'(tx_q.size()), 0, "R2 all tx bytes seen");

    // receive direction
    clr_status(7'h7F);
    chk(32'(irq_status), 32'h01, "R10 clear all");
    for (int i = 0; i < 3; i++) rx_push(8'(8'hA0 + i));
    chk(32'(fifo_status[22:16]), 3, "R4 rx level");
    chk(32'(irq_status[1]), 0, "R6 below threshold");
    rx_push(8'hA3);
    chk(32'(irq_status[1]), 0, "R6 not yet");
    @(negedge clk);
    chk(32'(irq_status[1]), 1, "R6 almost full");
    repeat (4) @(negedge clk);
    chk(32'(irq_status[6]), 0, "R9 trailing early");
    @(negedge clk);
    chk(32'(irq_status[6]), 1, "R9 trailing due");

    for (int i = 0; i < 4; i++) rx_pop();
    chk(32'(rx_q.size()), 0, "R3 all rx bytes seen");
    rx_pop();
    chk(32'(irq_status[4]), 1, "R8 rx underrun");

    for (int i = 0; i <= DEPTH; i++) rx_push(8'(8'h40 + i));
    chk(32'(irq_status[5]), 1, "R7 rx overrun");
    chk(32'(fifo_status[24:16]), 32'(9'h080 | DEPTH), "R4 rx full");

    // software reset
    soft_rst = 1'b1;
    #1;
    chk(32'({rx_in_ready, rx_out_valid, tx_in_ready}), 0, "R12 handshakes held");
    @(negedge clk);
    chk(fifo_status, 32'h0100_0100, "R12 queues flushed");
    chk(32'(irq_status), 0, "R12 status cleared");
    soft_rst = 1'b0;
    rx_q.delete();
    @(negedge clk);
    chk(32'(rx_out_valid), 0, "R12 rx stays empty");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule